// File: doc/BRIEF.md
# DMA Channel Set/Clear Register Bank

This block is the register slave of a 32-channel DMA engine. It keeps the per-channel control vectors: enable, request mask, burst-only, alternate-structure select and high priority. Software never writes these vectors directly. Each vector has a set address, where 1 bits turn bits on, and a paired clear address, where 1 bits turn bits off. The engine's sequencer and arbiter also drive one-cycle set and clear pulses into the same vectors. When a pulse and a bus write reach the same bit in the same clock, both are merged by a fixed precedence.

Besides the vectors, the bank holds the following:
- a configuration word with the master enable
- the control-table base pointer, plus the alternate base derived from it
- a software-request vector
- a channel-assignment vector
- four source-map words with one 4-bit field per channel
- a completion-interrupt status vector, cleared by writing 1
- a one-bit bus-error flag, cleared by writing 1

A read-only status word reports the channel count, the sequencer state and the master enable. The bus is a single-cycle valid/write/address/data port, and read data is combinational from the address.

Top module: `dma_chan_regs`

## Requirements
- R1: A write of 1 to bit n at a vector's set address turns bit n on, and 0 bits leave their bits unchanged. Reading either the set or the clear address returns the vector, zero-extended to 32 bits. The set/clear pairs are: burst-only 0x018/0x01C, request mask 0x020/0x024, enable 0x028/0x02C, alternate select 0x030/0x034, priority 0x038/0x03C.
- R2: A write of 1 to bit n at a vector's clear address turns bit n off. No write to a set address ever turns a bit off.
- R3: Hardware pulses act on the vectors as follows:
  - The enable vector has a hardware clear input.
  - The burst-only vector has a hardware clear input.
  - The alternate-select vector has both a hardware set input and a hardware clear input.
  - When a hardware set and a software clear reach the same bit in the same cycle, the bit ends at 1.
  - When a hardware clear and a software set reach the same bit in the same cycle, the bit ends at 0.
- R4: The status word at 0x000 reads NCH-1 in bits 20:16, the sequencer state in bits 7:4 and the master enable in bit 0, with all other bits 0. Writes to 0x000 have no effect. The master enable is bit 0 of the configuration word at 0x004.
- R5: The interrupt status vector at 0x504 behaves as follows:
  - A completion pulse for channel n sets bit n.
  - Writing 1 to bit n clears it.
  - A completion pulse in the same cycle as a write-1 to the same bit leaves the bit at 1.
- R6: The bus error flag is bit 0 at 0x04C. A hardware error pulse sets it. Writing 1 clears it, and writing 0 leaves it unchanged.
- R7: The map words at 0x510, 0x514, 0x518 and 0x51C are read/write. Channel n takes its 4-bit source select from bits 4*(n mod 8)+3 : 4*(n mod 8) of map word n/8.
- R8: The control base at 0x008 keeps bits 31:10 and reads 0 in bits 9:0. The alternate base at 0x00C reads the control base plus NCH*16.
- R9: While reset is asserted, every read returns 0. After reset, all vectors, flags and words are 0.
- R10: Any offset not listed in these requirements reads 0, and writes to it change nothing. The address is decoded on all 12 bits.
- R11: The software-request vector at 0x014 behaves as follows:
  - Writing 1 to a bit sets it.
  - A hardware completion-clear pulse clears it.
  - When the pulse and a software set reach the same bit in the same cycle, the clear wins.
  - Reads return the current vector.
- R12: The wait status at 0x010 reads the wait-request input live. The channel-assignment vector at 0x500 is plain read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| seq_state | input | 4 | Sequencer state shown in status |
| wait_req | input | NCH | Per-channel waiting-on-request flags |
| hw_en_clr | input | NCH | Hardware enable clear (cycle done) |
| hw_burst_clr | input | NCH | Hardware burst-only clear |
| hw_alt_set | input | NCH | Hardware alternate-select set |
| hw_alt_clr | input | NCH | Hardware alternate-select clear |
| hw_swreq_clr | input | NCH | Hardware software-request clear |
| hw_done | input | NCH | Completion pulse, sets interrupt status |
| hw_bus_err | input | 1 | Bus error pulse |
| master_en | output | 1 | Controller master enable |
| ctl_base | output | 32 | Control table base pointer |
| ch_enable | output | NCH | Channel enable vector |
| ch_reqmask | output | NCH | Request mask vector |
| ch_burst_only | output | NCH | Burst-only vector |
| ch_alt | output | NCH | Alternate-structure select vector |
| ch_prio | output | NCH | High-priority vector |
| ch_swreq | output | NCH | Pending software requests |
| ch_assign | output | NCH | Channel assignment vector |
| ch_irq | output | NCH | Interrupt status vector |
| bus_err | output | 1 | Bus error flag |
| ch_src | output | 4*NCH | Per-channel source select fields |

## Verification
The hardest cases to reach from the ports are same-cycle collisions, where a hardware pulse and a software set or clear write land on the same bit at the same clock edge. These collisions decide R3, R5 and R11. A sequencer in normal operation almost never lines them up.

The bench drives every cycle through one step task. That task places the bus write and any chosen hardware pulses into the same clock. It then reads the vector back through its set address. This lets each precedence rule be provoked in isolation on a chosen bit, while neighbouring bits show that their own state is untouched.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CONFIG = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CBASE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ABASE  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_WAIT   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SWREQ  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_PAIR0  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_ERR    = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_ASSIGN = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_IRQ    = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_MAP0   = 12'h510;

  // set/clear pairs, in address order (pair k: set at PAIR0+8k, clear at +4)
  localparam int unsigned NUM_PAIRS   = 5;
  localparam int unsigned PAIR_BURST  = 0;
  localparam int unsigned PAIR_MASK   = 1;
  localparam int unsigned PAIR_ENABLE = 2;
  localparam int unsigned PAIR_ALT    = 3;
  localparam int unsigned PAIR_PRIO   = 4;

  localparam int unsigned SRC_W       = 4;
  localparam int unsigned SRC_PER_MAP = DATA_W / SRC_W;
  localparam int unsigned CTRL_BYTES  = 16;
  localparam int unsigned CBASE_LSB   = 10;

  // precedence: hw clear > hw set > sw clear > sw set > hold
  function automatic logic [DATA_W-1:0] merge_setclr(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] sw_set,
      input logic [DATA_W-1:0] sw_clr, input logic [DATA_W-1:0] hw_set,
      input logic [DATA_W-1:0] hw_clr);
    return (((cur | sw_set) & ~sw_clr) | hw_set) & ~hw_clr;
  endfunction

  // write-one-to-clear with hardware set taking precedence
  function automatic logic [DATA_W-1:0] w1c_next(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] sw_clr,
      input logic [DATA_W-1:0] hw_set);
    return (cur & ~sw_clr) | hw_set;
  endfunction

  function automatic logic [DATA_W-1:0] alt_base_of(
      input logic [DATA_W-1:0] cbase, input int unsigned nch);
    return cbase + DATA_W'(nch * CTRL_BYTES);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(
      input int unsigned nch, input logic [3:0] st, input logic men);
    return {11'b0, 5'(nch - 1), 8'b0, st, 3'b0, men};
  endfunction

  function automatic logic [ADDR_W-1:0] pair_set_ofs(input int unsigned k);
    return ADDR_W'(OFS_PAIR0 + ADDR_W'(8 * k));
  endfunction

  function automatic logic [ADDR_W-1:0] map_ofs(input int unsigned m);
    return ADDR_W'(OFS_MAP0 + ADDR_W'(4 * m));
  endfunction
endpackage

// File: rtl/dmareg_setclr.sv
module dmareg_setclr
  import dmareg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else q <= W'(merge_setclr(DATA_W'(q), DATA_W'(sw_set), DATA_W'(sw_clr),
                              DATA_W'(hw_set), DATA_W'(hw_clr)));
  end

  // R1: software set bits not hit by a hardware clear end at 1
  a_r1_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_set & ~hw_clr)) |=> ((q & $past(sw_set & ~hw_clr)) == $past(sw_set & ~hw_clr)));
  // R2: software clear bits not hit by a hardware set end at 0
  a_r2_sw_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr & ~hw_set)) |=> ((q & $past(sw_clr & ~hw_set)) == '0));
  // R2: a bit only falls when some clear request targeted it
  a_r2_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(q) & ~q & ~$past(sw_clr | hw_clr)) == '0));
  // R3: hardware set beats software clear
  a_r3_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & ~hw_clr)) |=> ((q & $past(hw_set & ~hw_clr)) == $past(hw_set & ~hw_clr)));
  // R3: hardware clear beats software set
  a_r3_hw_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_clr) |=> ((q & $past(hw_clr)) == '0));
endmodule

// File: rtl/dmareg_w1c.sv
module dmareg_w1c
  import dmareg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else q <= W'(w1c_next(DATA_W'(q), DATA_W'(sw_clr), DATA_W'(hw_set)));
  end

  // R5 / R6: a hardware event always leaves its bit set
  a_r5_hw_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));
  // R5 / R6: write-1 clears bits with no simultaneous event
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr & ~hw_set)) |=> ((q & $past(sw_clr & ~hw_set)) == '0));
  // R5 / R6: a bit only rises on a hardware event
  a_r6_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(q) & q & ~$past(hw_set)) == '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmareg_pkg::*;
#(
  parameter int unsigned NCH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        seq_state,
  input  logic [NCH-1:0]    wait_req,
  input  logic [NCH-1:0]    hw_en_clr,
  input  logic [NCH-1:0]    hw_burst_clr,
  input  logic [NCH-1:0]    hw_alt_set,
  input  logic [NCH-1:0]    hw_alt_clr,
  input  logic [NCH-1:0]    hw_swreq_clr,
  input  logic [NCH-1:0]    hw_done,
  input  logic              hw_bus_err,
  output logic              master_en,
  output logic [31:0]       ctl_base,
  output logic [NCH-1:0]    ch_enable,
  output logic [NCH-1:0]    ch_reqmask,
  output logic [NCH-1:0]    ch_burst_only,
  output logic [NCH-1:0]    ch_alt,
  output logic [NCH-1:0]    ch_prio,
  output logic [NCH-1:0]    ch_swreq,
  output logic [NCH-1:0]    ch_assign,
  output logic [NCH-1:0]    ch_irq,
  output logic              bus_err,
  output logic [4*NCH-1:0]  ch_src
);
  localparam int unsigned NMAP = (NCH + SRC_PER_MAP - 1) / SRC_PER_MAP;
  localparam int unsigned CB_W = DATA_W - CBASE_LSB;

  // named bus events
  logic wr_en, rd_en;
  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  logic wr_swreq, wr_irq, wr_err;
  assign wr_swreq = wr_en && (bus_addr == OFS_SWREQ);
  assign wr_irq   = wr_en && (bus_addr == OFS_IRQ);
  assign wr_err   = wr_en && (bus_addr == OFS_ERR);

  // ---------------- set/clear vector pairs ----------------
  logic [NCH-1:0] sw_set_v [NUM_PAIRS];
  logic [NCH-1:0] sw_clr_v [NUM_PAIRS];
  logic [NCH-1:0] hw_set_v [NUM_PAIRS];
  logic [NCH-1:0] hw_clr_v [NUM_PAIRS];
  logic [NCH-1:0] vec_q    [NUM_PAIRS];

  always_comb begin
    for (int k = 0; k < NUM_PAIRS; k++) begin
      hw_set_v[k] = '0;
      hw_clr_v[k] = '0;
    end
    hw_clr_v[PAIR_BURST]  = hw_burst_clr;
    hw_clr_v[PAIR_ENABLE] = hw_en_clr;
    hw_set_v[PAIR_ALT]    = hw_alt_set;
    hw_clr_v[PAIR_ALT]    = hw_alt_clr;
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    localparam logic [ADDR_W-1:0] SET_OFS = pair_set_ofs(k);
    localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(SET_OFS + 12'h004);
    assign sw_set_v[k] = (wr_en && bus_addr == SET_OFS) ? bus_wdata[NCH-1:0] : '0;
    assign sw_clr_v[k] = (wr_en && bus_addr == CLR_OFS) ? bus_wdata[NCH-1:0] : '0;
    dmareg_setclr #(.W(NCH)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .sw_set(sw_set_v[k]), .sw_clr(sw_clr_v[k]),
      .hw_set(hw_set_v[k]), .hw_clr(hw_clr_v[k]),
      .q(vec_q[k])
    );
  end

  assign ch_burst_only = vec_q[PAIR_BURST];
  assign ch_reqmask    = vec_q[PAIR_MASK];
  assign ch_enable     = vec_q[PAIR_ENABLE];
  assign ch_alt        = vec_q[PAIR_ALT];
  assign ch_prio       = vec_q[PAIR_PRIO];

  // ---------------- software request: sw sets, hw clears ----------------
  logic [NCH-1:0] swreq_set;
  assign swreq_set = wr_swreq ? bus_wdata[NCH-1:0] : '0;

  dmareg_setclr #(.W(NCH)) u_swreq (
    .clk(clk), .rst_n(rst_n),
    .sw_set(swreq_set), .sw_clr('0),
    .hw_set('0), .hw_clr(hw_swreq_clr),
    .q(ch_swreq)
  );

  // ---------------- write-one-to-clear status ----------------
  logic [NCH-1:0] irq_clr;
  logic           err_clr;
  assign irq_clr = wr_irq ? bus_wdata[NCH-1:0] : '0;
  assign err_clr = wr_err & bus_wdata[0];

  dmareg_w1c #(.W(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .sw_clr(irq_clr), .hw_set(hw_done), .q(ch_irq)
  );

  dmareg_w1c #(.W(1)) u_err (
    .clk(clk), .rst_n(rst_n), .sw_clr(err_clr), .hw_set(hw_bus_err), .q(bus_err)
  );

  // ---------------- plain read/write words ----------------
  logic            cfg_q;
  logic [CB_W-1:0] cbase_q;
  logic [NCH-1:0]  assign_q;
  logic [31:0]     map_q [NMAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 1'b0;
      cbase_q  <= '0;
      assign_q <= '0;
      for (int m = 0; m < NMAP; m++) map_q[m] <= '0;
    end else if (wr_en) begin
      if (bus_addr == OFS_CONFIG) cfg_q    <= bus_wdata[0];
      if (bus_addr == OFS_CBASE)  cbase_q  <= bus_wdata[DATA_W-1:CBASE_LSB];
      if (bus_addr == OFS_ASSIGN) assign_q <= bus_wdata[NCH-1:0];
      for (int m = 0; m < NMAP; m++)
        if (bus_addr == map_ofs(m)) map_q[m] <= bus_wdata;
    end
  end

  assign master_en = cfg_q;
  assign ctl_base  = {cbase_q, {CBASE_LSB{1'b0}}};
  assign ch_assign = assign_q;

  for (genvar n = 0; n < NCH; n++) begin : g_src
    assign ch_src[SRC_W*n +: SRC_W] = map_q[n / SRC_PER_MAP][SRC_W*(n % SRC_PER_MAP) +: SRC_W];
  end

  // ---------------- read mux ----------------
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_STATUS: rd_mux = status_word(NCH, seq_state, cfg_q);
      OFS_CONFIG: rd_mux = {31'b0, cfg_q};
      OFS_CBASE:  rd_mux = ctl_base;
      OFS_ABASE:  rd_mux = alt_base_of(ctl_base, NCH);
      OFS_WAIT:   rd_mux = DATA_W'(wait_req);
      OFS_SWREQ:  rd_mux = DATA_W'(ch_swreq);
      OFS_ERR:    rd_mux = {31'b0, bus_err};
      OFS_ASSIGN: rd_mux = DATA_W'(assign_q);
      OFS_IRQ:    rd_mux = DATA_W'(ch_irq);
      default:    rd_mux = '0;
    endcase
    for (int k = 0; k < NUM_PAIRS; k++)
      if (bus_addr == pair_set_ofs(k) || bus_addr == ADDR_W'(pair_set_ofs(k) + 12'h004))
        rd_mux = DATA_W'(vec_q[k]);
    for (int m = 0; m < NMAP; m++)
      if (bus_addr == map_ofs(m)) rd_mux = map_q[m];
  end

  assign bus_rdata = rst_n ? rd_mux : '0;

  // R9: reads are quiet while reset is held
  always_comb begin
    if (!rst_n) a_r9_reset_quiet: assert (bus_rdata == '0);
  end
  // R4: status read carries the channel count and master enable
  a_r4_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_STATUS) |-> (bus_rdata[20:16] == 5'(NCH - 1) && bus_rdata[0] == master_en));
  // R12: wait status mirrors the live input
  a_r12_wait_live: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_WAIT) |-> (bus_rdata == DATA_W'(wait_req)));
  // R8: alternate base sits NCH control entries above the control base
  a_r8_alt_base: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_ABASE) |-> (bus_rdata - ctl_base == DATA_W'(NCH * CTRL_BYTES)));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  localparam int NCH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  seq_state = 4'd5;
  logic [NCH-1:0] wait_req = 32'hA5A5_0000;
  logic [NCH-1:0] hw_en_clr = '0, hw_burst_clr = '0, hw_alt_set = '0, hw_alt_clr = '0;
  logic [NCH-1:0] hw_swreq_clr = '0, hw_done = '0;
  logic hw_bus_err = 0;
  logic master_en, bus_err;
  logic [31:0] ctl_base;
  logic [NCH-1:0] ch_enable, ch_reqmask, ch_burst_only, ch_alt, ch_prio, ch_swreq, ch_assign, ch_irq;
  logic [4*NCH-1:0] ch_src;

  dma_chan_regs #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_state(seq_state), .wait_req(wait_req), .hw_en_clr(hw_en_clr),
    .hw_burst_clr(hw_burst_clr), .hw_alt_set(hw_alt_set), .hw_alt_clr(hw_alt_clr),
    .hw_swreq_clr(hw_swreq_clr), .hw_done(hw_done), .hw_bus_err(hw_bus_err),
    .master_en(master_en), .ctl_base(ctl_base), .ch_enable(ch_enable),
    .ch_reqmask(ch_reqmask), .ch_burst_only(ch_burst_only), .ch_alt(ch_alt),
    .ch_prio(ch_prio), .ch_swreq(ch_swreq), .ch_assign(ch_assign), .ch_irq(ch_irq),
    .bus_err(bus_err), .ch_src(ch_src)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int total = 0, bad = 0;

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (bus_valid && !bus_write) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty: act=%h exp=<none>", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%h act=%h exp=%h", it.tag, bus_addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step(input logic v, input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] hen, input logic [31:0] hbu, input logic [31:0] has,
                      input logic [31:0] hac, input logic [31:0] hsw, input logic [31:0] hdn,
                      input logic herr);
    @(posedge clk); #2;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    hw_en_clr = hen; hw_burst_clr = hbu; hw_alt_set = has; hw_alt_clr = hac;
    hw_swreq_clr = hsw; hw_done = hdn; hw_bus_err = herr;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 12'h0, 32'h0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    step(1, 0, a, 32'h0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    @(negedge clk);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, e);
    end
  endtask

  initial begin
    // R9: reads are zero while reset is asserted
    rd(12'h000, 32'h0, "R9 status in reset");
    rd(12'h010, 32'h0, "R9 wait status in reset");
    @(posedge clk); #2; rst_n = 1'b1;
    bus_valid = 0;

    // R4 / R9
    rd(12'h000, 32'h001F_0050, "R4 status after reset");
    rd(12'h028, 32'h0, "R9 enable vector after reset");
    wr(12'h004, 32'h1);
    rd(12'h000, 32'h001F_0051, "R4 status with master enable");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h001F_0051, "R4 status ignores writes");

    // R1 / R2 enable pair
    wr(12'h028, 32'h0000_00F0);
    rd(12'h028, 32'h0000_00F0, "R1 enable set");
    wr(12'h028, 32'h0000_0003);
    rd(12'h02C, 32'h0000_00F3, "R1 zeros leave bits, clear address reads vector");
    wr(12'h02C, 32'h0000_0011);
    rd(12'h028, 32'h0000_00E2, "R2 enable clear");

    // R3 collisions on the alternate select vector
    wr(12'h030, 32'h0000_000C);
    step(1, 1, 12'h034, 32'h4, 0, 0, 32'h4, 0, 0, 0, 0);
    rd(12'h030, 32'h0000_000C, "R3 hw set beats sw clear");
    step(1, 1, 12'h030, 32'h1, 0, 0, 0, 32'h1, 0, 0, 0);
    rd(12'h030, 32'h0000_000C, "R3 hw clear beats sw set");
    step(0, 0, 12'h0, 32'h0, 0, 0, 32'h100, 0, 0, 0, 0);
    rd(12'h034, 32'h0000_010C, "R3 hw alternate set alone");

    // R3 / R5 channel completion
    step(0, 0, 12'h0, 32'h0, 32'h80, 0, 0, 0, 0, 32'h80, 0);
    rd(12'h028, 32'h0000_0062, "R3 hw enable clear");
    rd(12'h504, 32'h0000_0080, "R5 completion sets status");
    chk("R3 ch_enable port", ch_enable, 32'h0000_0062);
    step(1, 1, 12'h504, 32'h80, 0, 0, 0, 0, 0, 32'h1, 0);
    rd(12'h504, 32'h0000_0001, "R5 w1c with new event on other bit");
    step(1, 1, 12'h504, 32'h1, 0, 0, 0, 0, 0, 32'h1, 0);
    rd(12'h504, 32'h0000_0001, "R5 event beats w1c on same bit");
    wr(12'h504, 32'h1);
    rd(12'h504, 32'h0, "R5 w1c clears");

    // R6 bus error flag
    step(0, 0, 12'h0, 32'h0, 0, 0, 0, 0, 0, 0, 1);
    rd(12'h04C, 32'h1, "R6 error set by hardware");
    wr(12'h04C, 32'h0);
    rd(12'h04C, 32'h1, "R6 writing zero keeps flag");
    wr(12'h04C, 32'h1);
    rd(12'h04C, 32'h0, "R6 w1c clears flag");

    // R8 bases
    wr(12'h008, 32'h2000_07FF);
    rd(12'h008, 32'h2000_0400, "R8 control base low bits zero");
    rd(12'h00C, 32'h2000_0600, "R8 alternate base");

    // R7 maps
    wr(12'h510, 32'h8765_4321);
    wr(12'h51C, 32'hF000_000A);
    rd(12'h510, 32'h8765_4321, "R7 map word readback");
    idle();
    chk("R7 channel 0 source", {28'h0, ch_src[3:0]}, 32'h1);
    chk("R7 channel 7 source", {28'h0, ch_src[31:28]}, 32'h8);
    chk("R7 channel 24 source", {28'h0, ch_src[99:96]}, 32'hA);
    chk("R7 channel 31 source", {28'h0, ch_src[127:124]}, 32'hF);

    // R10 unmapped offsets
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h0, "R10 unmapped 0x040");
    rd(12'h508, 32'h0, "R10 unmapped 0x508");
    rd(12'h520, 32'h0, "R10 unmapped 0x520");
    rd(12'h02A, 32'h0, "R10 unaligned offset");

    // R11 software request
    wr(12'h014, 32'h5);
    rd(12'h014, 32'h5, "R11 software request set");
    step(1, 1, 12'h014, 32'h1, 0, 0, 0, 0, 32'h1, 0, 0);
    rd(12'h014, 32'h4, "R11 hw clear beats sw set");

    // R12 wait status and assignment
    rd(12'h010, 32'hA5A5_0000, "R12 wait status live");
    wr(12'h500, 32'h1234_5678);
    rd(12'h500, 32'h1234_5678, "R12 assignment readback");
    chk("R12 ch_assign port", ch_assign, 32'h1234_5678);

    // R1 / R2 / R3 other pairs
    wr(12'h018, 32'h0000_00FF);
    step(0, 0, 12'h0, 32'h0, 0, 32'h0F, 0, 0, 0, 0, 0);
    rd(12'h018, 32'h0000_00F0, "R3 hw burst-only clear");
    wr(12'h038, 32'h8000_0001);
    wr(12'h03C, 32'h0000_0001);
    rd(12'h03C, 32'h8000_0000, "R2 priority clear");
    wr(12'h020, 32'h0000_0003);
    rd(12'h024, 32'h0000_0003, "R1 request mask set");
    idle();
    chk("R1 ch_reqmask port", ch_reqmask, 32'h3);
    chk("R4 master_en port", {31'h0, master_en}, 32'h1);

    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired: act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule